// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block turns single access requests from an on-chip bus master into command sequences for a synchronous DRAM with a 32-bit data path. A request carries a byte address, a direction flag and a size flag, which selects one 32-bit word or a 32-byte line. The sequencer opens the row and waits an activate-to-column interval. It then issues the column commands, moves the data beats and closes the bank with auto-precharge. It waits out the recovery intervals before it accepts the next request. Only one request is in flight at a time.

A 32-byte transfer is handled as two 16-byte halves. Each half is a four-beat burst. For a 32-byte write, the first half goes out as a plain write. The second half goes out four cycles later as a write with auto-precharge. A programmable write-recovery interval and a precharge wait follow, and no command is issued during either. A one-word read opens the row, issues a read with auto-precharge and receives four data beats after a fixed CAS latency of three cycles. A one-word write masks the unselected byte lanes. The current timing state is brought out as a phase code so that the master or a monitor can follow the sequence.

Top module: `sdram_burst_seq`

## Requirements
- R1: `req_ready` is high only in the idle phase. After a request is accepted, it stays low for exactly 1 + Trw + Tc + Trwl + Tpc cycles. Here Trw = max(cfg_trw,1) and Tpc = max(cfg_tpc,1). Tc is 1 for a one-word write, 8 for a 32-byte write, 7 for a one-word read and 11 for a 32-byte read. Trwl is cfg_trwl for writes and 0 for reads. A `req_valid` held high while busy starts no extra access.
- R2: In the cycle after acceptance, ACTV ({cs_n,ras_n,cas_n,we_n} = 0011) is issued with the row (byte address bits 21:10) on `sd_addr` and the bank (bits 23:22) on `sd_bank`.
- R3: After ACTV come Trw NOP (0111) cycles. The first column command follows in the next cycle, 1 + Trw cycles after ACTV.
- R4: A one-word read issues READ (0101) once, with the column (byte address bits 9:2) and `sd_addr[10]` = 1 for auto-precharge. `rd_valid` is high for the four cycles that start three cycles after READ. Then the Tpc phase follows.
- R5: A 32-byte write issues WRIT (0100) with column bits 2:0 cleared and `sd_addr[10]` = 0. Exactly four cycles later it issues WRIT with column bits 2:0 = 100 and `sd_addr[10]` = 1. The cycles in between are NOPs.
- R6: `sd_dq_oe` is high on every write beat: 8 cycles for a 32-byte write, starting with the first WRIT, and 1 cycle for a one-word write. In those cycles `sd_dq_out` equals `req_wdata`.
- R7: After the last write beat, the Trwl phase (phase code 4) lasts cfg_trwl cycles and is skipped when cfg_trwl is 0. The Tpc phase (code 5) follows. Only NOPs are issued in both phases.
- R8: A one-word write issues a single WRIT with the column and `sd_addr[10]` = 1. On that beat `sd_dqm` = ~`req_be`.
- R9: `sd_dqm` is 0 in every cycle except the beat of a one-word write.
- R10: A 32-byte read issues READ with `sd_addr[10]` = 0 and column bits 2:0 cleared. Four cycles later it issues READ with `sd_addr[10]` = 1 and column bits 2:0 = 100. `rd_valid` is high for eight cycles, starting three cycles after the first READ.
- R11: In the idle phase `sd_cs_n` is 1. `sd_cke` is always 1. The phase codes are idle 0, Tr 1, Trw 2, Tc/Td 3, Trwl 4 and Tpc 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = 32-byte line, 0 = one word |
| req_addr | input | 24 | Byte address |
| req_be | input | 4 | Byte-lane enables for one-word writes |
| req_wdata | input | 32 | Write data for the current beat |
| cfg_trw | input | 3 | Activate-to-column NOP count (0 treated as 1) |
| cfg_trwl | input | 3 | Write-recovery count |
| cfg_tpc | input | 3 | Precharge wait count (0 treated as 1) |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_bank | output | 2 | Bank select |
| sd_addr | output | 12 | Row or column address, bit 10 = auto-precharge |
| sd_dqm | output | 4 | Byte-lane masks |
| sd_dq_out | output | 32 | Write data to the DRAM |
| sd_dq_oe | output | 1 | Write data drive enable / beat taken |
| sd_dq_in | input | 32 | Read data from the DRAM |
| rd_data | output | 32 | Read data to the master |
| rd_valid | output | 1 | Read data beat valid |
| phase_o | output | 3 | Current timing phase code |

## Verification
The case that is hardest to reach from the ports is the tail of a 32-byte write that carries the largest recovery settings. Every beat must have been driven by then, and a late command or a mask error would only show at the edge of a long quiet window. The stimulus table includes a 32-byte write with all three timing fields at 7 and a one-word write with Trwl = 7, so both the full Trwl and the full Tpc windows are observed cycle by cycle. Other cases hold `req_valid` high across several back-to-back accesses, and reset the block in the middle of a burst write.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TR   = 3'd1,
    PH_TRW  = 3'd2,
    PH_TC   = 3'd3,
    PH_TRWL = 3'd4,
    PH_TPC  = 3'd5
  } phase_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESL = 4'b1111;
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_ACTV = 4'b0011;
  localparam logic [3:0] CMD_READ = 4'b0101;
  localparam logic [3:0] CMD_WRIT = 4'b0100;

  localparam int HALF_BEATS = 4;
  localparam int LINE_BEATS = 2 * HALF_BEATS;

  // Wait counts where zero is promoted to one cycle
  function automatic int min_one(input int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  // Cycles spent in the column / data phase
  function automatic int col_phase_len(input logic wr, input logic line, input int cas_lat);
    if (wr) return line ? LINE_BEATS : 1;
    return cas_lat + (line ? LINE_BEATS : HALF_BEATS);
  endfunction

endpackage

// File: rtl/sdram_seq_cnt.sv
module sdram_seq_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdram_seq_addr.sv
module sdram_seq_addr #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic [COL_W+ROW_W+BANK_W+1:0] addr,
  input  logic                          line,
  input  logic                          upper_half,
  input  logic                          auto_pre,
  output logic [ROW_W-1:0]              row,
  output logic [ROW_W-1:0]              col_word,
  output logic [BANK_W-1:0]             bank
);
  localparam int WORD_LSB = 2;
  localparam int ROW_LSB  = WORD_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  function automatic logic [ROW_W-1:0] make_col(input logic [COL_W-1:0] c,
                                                input logic ln, input logic up,
                                                input logic ap);
    logic [ROW_W-1:0] w;
    w = '0;
    if (ln) w[COL_W-1:0] = {c[COL_W-1:3], up, 2'b00};
    else    w[COL_W-1:0] = c;
    w[AP_BIT] = ap;
    return w;
  endfunction

  logic [COL_W-1:0] col;
  assign col      = addr[ROW_LSB-1:WORD_LSB];
  assign row      = addr[BANK_LSB-1:ROW_LSB];
  assign bank     = addr[BANK_LSB+BANK_W-1:BANK_LSB];
  assign col_word = make_col(col, line, upper_half, auto_pre);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int ROW_W   = 12,
  parameter int BANK_W  = 2,
  parameter int CFG_W   = 3,
  parameter int CAS_LAT = 3,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic                          req_burst,
  input  logic [COL_W+ROW_W+BANK_W+1:0] req_addr,
  input  logic [DATA_W/8-1:0]           req_be,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [CFG_W-1:0]              cfg_trw,
  input  logic [CFG_W-1:0]              cfg_trwl,
  input  logic [CFG_W-1:0]              cfg_tpc,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_bank,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic [2:0]                    phase_o
);
  localparam int ADDR_W = COL_W + ROW_W + BANK_W + 2;
  localparam int LANES  = DATA_W / 8;
  localparam int MAX_PH = CAS_LAT + LINE_BEATS + (1 << CFG_W);
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  phase_e             phase_q, phase_nx;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q, line_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LANES-1:0]   be_q;
  logic [CFG_W-1:0]   trw_q, trwl_q, tpc_q;
  logic [CNT_W-1:0]   ph_len;
  logic               ph_last;

  // named events for the checker
  logic               accept_ev;
  logic               col_ev;
  logic               upper_ev;
  logic               wbeat_ev;
  logic               rbeat_ev;

  logic [ROW_W-1:0]   row_w, col_w;
  logic [BANK_W-1:0]  bank_w;
  logic [3:0]         cmd;

  assign accept_ev = (phase_q == PH_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      line_q <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      trw_q  <= '0;
      trwl_q <= '0;
      tpc_q  <= '0;
    end else if (accept_ev) begin
      wr_q   <= req_write;
      line_q <= req_burst;
      addr_q <= req_addr;
      be_q   <= req_be;
      trw_q  <= cfg_trw;
      trwl_q <= cfg_trwl;
      tpc_q  <= cfg_tpc;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_TRW:  ph_len = CNT_W'(min_one(int'(trw_q)));
      PH_TC:   ph_len = CNT_W'(col_phase_len(wr_q, line_q, CAS_LAT));
      PH_TRWL: ph_len = CNT_W'(trwl_q);
      PH_TPC:  ph_len = CNT_W'(min_one(int'(tpc_q)));
      default: ph_len = CNT_W'(1);
    endcase
  end

  assign ph_last = (cnt == ph_len - 1'b1);

  always_comb begin
    phase_nx = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_nx = PH_TR;
      PH_TR:   phase_nx = PH_TRW;
      PH_TRW:  if (ph_last) phase_nx = PH_TC;
      PH_TC:   if (ph_last) phase_nx = (wr_q && trwl_q != '0) ? PH_TRWL : PH_TPC;
      PH_TRWL: if (ph_last) phase_nx = PH_TPC;
      PH_TPC:  if (ph_last) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nx;
  end

  sdram_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_nx != phase_q),
    .cnt   (cnt)
  );

  assign upper_ev = line_q && (cnt == CNT_W'(HALF_BEATS));
  assign col_ev   = (phase_q == PH_TC) && ((cnt == '0) || upper_ev);
  assign wbeat_ev = (phase_q == PH_TC) && wr_q;
  assign rbeat_ev = (phase_q == PH_TC) && !wr_q && (cnt >= CNT_W'(CAS_LAT));

  sdram_seq_addr #(
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .BANK_W(BANK_W)
  ) u_addr (
    .addr       (addr_q),
    .line       (line_q),
    .upper_half (upper_ev),
    .auto_pre   (!line_q || upper_ev),
    .row        (row_w),
    .col_word   (col_w),
    .bank       (bank_w)
  );

  always_comb begin
    if (phase_q == PH_IDLE)    cmd = CMD_DESL;
    else if (phase_q == PH_TR) cmd = CMD_ACTV;
    else if (col_ev)           cmd = wr_q ? CMD_WRIT : CMD_READ;
    else                       cmd = CMD_NOP;
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke    = 1'b1;
  assign sd_bank   = (phase_q == PH_IDLE) ? '0 : bank_w;
  assign sd_addr   = (phase_q == PH_TR) ? row_w : (col_ev ? col_w : '0);
  assign sd_dqm    = (wbeat_ev && !line_q) ? ~be_q : '0;
  assign sd_dq_out = req_wdata;
  assign sd_dq_oe  = wbeat_ev;
  assign rd_data   = sd_dq_in;
  assign rd_valid  = rbeat_ev;
  assign req_ready = (phase_q == PH_IDLE);
  assign phase_o   = phase_q;

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int ROW_W  = 12,
  parameter int LANES  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sd_cke,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [LANES-1:0] sd_dqm,
  input logic             sd_dq_oe,
  input logic             rd_valid,
  input logic [2:0]       phase_o
);
  localparam logic [2:0] P_TR = 3'd1, P_TC = 3'd3, P_TRWL = 3'd4, P_TPC = 3'd5;

  p_accept_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (phase_o == P_TR &&
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011));

  p_ready_after_tpc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(phase_o) == P_TPC);

  p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sd_cs_n && sd_cke));

  p_recover_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == P_TRWL || phase_o == P_TPC) |->
      ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111 && !sd_dq_oe));

  p_dqm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_dq_oe |-> sd_dqm == '0);

  p_rdv_in_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (phase_o == P_TC && !sd_dq_oe));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.ROW_W(ROW_W), .LANES(DATA_W/8)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_dqm    (sd_dqm),
  .sd_dq_oe  (sd_dq_oe),
  .rd_valid  (rd_valid),
  .phase_o   (phase_o)
);

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0, sd_dq_in = '0;
  logic [2:0]  cfg_trw = 3'd1, cfg_trwl = 3'd0, cfg_tpc = 3'd1;
  logic        req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_bank;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out, rd_data;
  logic        sd_dq_oe, rd_valid;
  logic [2:0]  phase_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdram_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .cfg_trw(cfg_trw),
    .cfg_trwl(cfg_trwl), .cfg_tpc(cfg_tpc), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_bank(sd_bank), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .phase_o(phase_o)
  );

  // {write, line, addr[23:0], be[3:0], trw, trwl, tpc}
  localparam int NV = 9;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 24'h123454, 4'hF, 3'd1, 3'd0, 3'd1},
    {1'b0, 1'b0, 24'h3FFFFC, 4'hF, 3'd0, 3'd0, 3'd0},
    {1'b0, 1'b0, 24'h0A0410, 4'hF, 3'd3, 3'd5, 3'd2},
    {1'b1, 1'b1, 24'h012368, 4'hF, 3'd1, 3'd2, 3'd1},
    {1'b1, 1'b1, 24'h2C07F4, 4'hF, 3'd2, 3'd0, 3'd3},
    {1'b1, 1'b0, 24'h00088C, 4'b0101, 3'd1, 3'd1, 3'd1},
    {1'b1, 1'b0, 24'h155540, 4'b1000, 3'd2, 3'd7, 3'd2},
    {1'b0, 1'b1, 24'h3381E0, 4'hF, 3'd2, 3'd4, 3'd1},
    {1'b1, 1'b1, 24'h3FFFE4, 4'hF, 3'd7, 3'd7, 3'd7}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [38:0] v);
    logic wr, ln;
    int trwE, tpcE, trwlE, tclen, total, c1, row, bank, col, base;
    int nact, act_k, act_addr, act_bank, ncol, nrdv, rdv_k, noe, dbad, dqbad, ntrwl, quiet, busy;
    int colk[2], cola[2], colc[2];
    string rq;
    wr = v[38]; ln = v[37];
    trwE  = (v[8:6] == 0) ? 1 : int'(v[8:6]);
    tpcE  = (v[2:0] == 0) ? 1 : int'(v[2:0]);
    trwlE = wr ? int'(v[5:3]) : 0;
    tclen = wr ? (ln ? 8 : 1) : (3 + (ln ? 8 : 4));
    total = 1 + trwE + tclen + trwlE + tpcE;
    c1    = 1 + trwE;
    row   = int'((v[36:13] >> 10) & 24'hFFF);
    bank  = int'(v[36:13] >> 22);
    col   = int'((v[36:13] >> 2) & 24'hFF);
    base  = col & ~7;
    rq = wr ? (ln ? "R5" : "R8") : (ln ? "R10" : "R4");
    nact = 0; act_k = -1; act_addr = -1; act_bank = -1; ncol = 0; nrdv = 0; rdv_k = -1;
    noe = 0; dbad = 0; dqbad = 0; ntrwl = 0; quiet = 0; busy = 0;
    colk = '{-1, -1}; cola = '{-1, -1}; colc = '{-1, -1};

    @(negedge clk);
    req_write = wr; req_burst = ln; req_addr = v[36:13]; req_be = v[12:9];
    cfg_trw = v[8:6]; cfg_trwl = v[5:3]; cfg_tpc = v[2:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      logic [3:0] cmd;
      logic [3:0] edqm;
      req_wdata = 32'hA500_0000 | k;
      sd_dq_in  = 32'h5A00_0000 | k;
      #1;
      if (req_ready) break;
      busy++;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (cmd == 4'b0011) begin
        nact++; act_k = k; act_addr = int'(sd_addr); act_bank = int'(sd_bank);
      end
      if (cmd == 4'b0101 || cmd == 4'b0100) begin
        if (ncol < 2) begin
          colk[ncol] = k; cola[ncol] = int'(sd_addr); colc[ncol] = int'(cmd);
        end
        ncol++;
      end
      if (rd_valid) begin
        if (nrdv == 0) rdv_k = k;
        nrdv++;
      end
      if (sd_dq_oe) begin
        noe++;
        if (sd_dq_out != req_wdata) dbad++;
      end
      edqm = (sd_dq_oe && wr && !ln) ? ~v[12:9] : 4'h0;
      if (sd_dqm != edqm) dqbad++;
      if (phase_o == 3'd4) ntrwl++;
      if ((phase_o == 3'd4 || phase_o == 3'd5) && cmd != 4'b0111) quiet++;
      @(negedge clk);
    end

    check("R1 busy cycles", busy, total);
    check("R2 ACTV count", nact, 1);
    check("R2 ACTV cycle", act_k, 0);
    check("R2 row address", act_addr, row);
    check("R2 bank", act_bank, bank);
    check("R3 first column cycle", colk[0], c1);
    check({rq, " column command count"}, ncol, ln ? 2 : 1);
    check({rq, " first column cmd"}, colc[0], wr ? 4 : 5);
    check({rq, " first column addr"}, cola[0], ln ? base : (col | 1024));
    if (ln) begin
      check({rq, " second column cycle"}, colk[1], c1 + 4);
      check({rq, " second column cmd"}, colc[1], wr ? 4 : 5);
      check({rq, " second column addr"}, cola[1], base | 4 | 1024);
    end
    check({rq, " rd_valid beats"}, nrdv, wr ? 0 : (ln ? 8 : 4));
    if (!wr) check({rq, " first rd_valid cycle"}, rdv_k, c1 + 3);
    check("R6 write beats", noe, wr ? (ln ? 8 : 1) : 0);
    check("R6 write data mismatches", dbad, 0);
    check("R9 R8 dqm mismatches", dqbad, 0);
    check("R7 Trwl cycles", ntrwl, trwlE);
    check("R7 commands in recovery", quiet, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    check("R1 ready after reset", int'(req_ready), 1);
    check("R11 cs_n idle", int'(sd_cs_n), 1);
    check("R11 cke", int'(sd_cke), 1);
    check("R9 dqm idle", int'(sd_dqm), 0);
    check("R11 phase idle", int'(phase_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // valid held high: each access starts once, period 11 cycles
    @(negedge clk);
    begin
      int nact;
      nact = 0;
      req_write = 1'b0; req_burst = 1'b0; req_addr = 24'h001000;
      cfg_trw = 3'd1; cfg_trwl = 3'd0; cfg_tpc = 3'd1; req_valid = 1'b1;
      for (int k = 0; k < 44; k++) begin
        #1;
        if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011) nact++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check("R1 ACTV count with valid held", nact, 4);
    end
    while (!req_ready) @(negedge clk);

    // reset in the middle of a line write
    req_write = 1'b1; req_burst = 1'b1; req_addr = 24'h000200; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 mid-burst beat active", int'(sd_dq_oe), 1);
    rst_n = 1'b0;
    #1;
    check("R1 ready after mid-burst reset", int'(req_ready), 1);
    check("R11 phase after mid-burst reset", int'(phase_o), 0);
    check("R11 cs_n after mid-burst reset", int'(sd_cs_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VEC[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule